// File: doc/BRIEF.md
# Quasi-Bidirectional Parallel Port Bank

This block holds the output bit latches of a bank of microcontroller parallel ports and turns them into per-pin pad driver controls. Port 0 is an open-drain port: a latch 0 pulls the pin low and a latch 1 leaves it floating. While the external memory bus is active, port 0 instead drives the address/data value with both a strong pull-down and a strong pull-up. The remaining ports are quasi-bidirectional. A latch 0 pulls the pin low. A latch 1 hands the pin to a weak pull-up, gated by the pin's alternate output function. Each rising edge of the driven value adds a short burst of strong pull-up.

Pad drivers do not see a latch write at once. A twelve-phase sequencer (six states of two phases each) lets the driver stage follow the latches only during Phase 1 of each state and hold during Phase 2. A write made in the last phase of a machine cycle therefore reaches the pin at the first phase of the next one. Pin levels pass through a two-stage synchronizer. They feed the alternate input functions and normal port reads. A read-modify-write read returns the latch rather than the pin.

Top module: `pio_port_bank`

## Requirements
- R1: During and after reset, the latches of ports 0 and 3 hold all 1s and those of ports 1, 2, 4 and 5 hold all 0s. The phase sequencer starts at index 0 (State 1, Phase 1).
- R2: The phase index counts 0 to 11 and wraps. Even indices are Phase 1. A latch written at an odd index reaches the driver outputs in the next cycle. A latch written at an even index reaches them only two cycles later, and the drivers hold steady through Phase 2.
- R3: A driven bit of 0 enables only the pull-down (pd_en=1, spu_en=0, wpu_en=0). Pull-down and any pull-up are never enabled together on a bit.
- R4: On ports 1 to 5, a sampled latch bit of 1 drives the value of the matching alt_out bit: weak pull-up when it is 1, pull-down when it is 0.
- R5: On ports 1 to 5, a 0-to-1 change of the driven bit asserts spu_en for exactly two cycles (one state), starting with the cycle in which the bit becomes 1.
- R6: On port 0 with ext_bus_en low, a latch bit of 1 floats the pin: pd_en, spu_en and wpu_en are all 0. wpu_en is never set on port 0.
- R7: While ext_bus_en is high, port 0 drives ext_ad_out at once (spu_en=ext_ad_out, pd_en=~ext_ad_out). The port 0 latch is loaded with all 1s, which overrides a core write to port 0 in the same cycle.
- R8: A pin read (rd_latch=0) and alt_in return pad_in delayed by two clock edges.
- R9: A read-modify-write read (rd_latch=1) returns the latch of rd_port whatever the pad level. A port index of 6 or more reads 0 and writes to it are ignored.
- R10: Bit b of port p sits at flat index p*8+b on every flat bus. rd_port and wr_port carry the port number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, one edge per phase |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Core write strobe for a port latch |
| wr_port | input | 3 | Port number written |
| wr_data | input | 8 | Value written to the latch |
| rd_port | input | 3 | Port number read |
| rd_latch | input | 1 | 1: read-modify-write read of the latch, 0: pin read |
| rd_data | output | 8 | Read result |
| alt_out | input | 48 | Alternate output function values, all ports |
| alt_in | output | 48 | Synchronized pin levels for alternate inputs |
| ext_bus_en | input | 1 | External memory access in progress |
| ext_ad_out | input | 8 | Address/data value driven on port 0 during the access |
| pad_in | input | 48 | Raw pin levels from the pads |
| pd_en | output | 48 | Strong pull-down enable per pin |
| spu_en | output | 48 | Strong pull-up enable per pin |
| wpu_en | output | 48 | Weak pull-up enable per pin |

## Verification
Two functions can act on the port 0 latch in one cycle: a core write and an external bus access. The bench asserts wr_en for port 0 with data 00 in the same cycle that ext_bus_en goes high. It judges the pad controls in that cycle against ext_ad_out and then reads the latch back through a read-modify-write read, expecting FF. A second overlap puts a latch write in a Phase 1 cycle, where the write and the driver sampling share a clock edge. The bench checks that the pins stay at the old value for one cycle before they change.

// File: rtl/pio_pkg.sv
// Shared constants and helpers for the port bank.
// Assumes six states of two phases per machine cycle.
package pio_pkg;
    localparam int unsigned STATES_PER_CYCLE = 6;
    localparam int unsigned PHASES_PER_STATE = 2;

    // Ports whose latches come out of reset as all ones.
    function automatic logic resets_high(input int unsigned port_no);
        return (port_no == 0) || (port_no == 3);
    endfunction
endpackage

// File: rtl/pio_phase_seq.sv
// Phase sequencer: counts phases within a machine cycle and flags Phase 1.
// Assumes one clk edge per phase; reset parks it on the first phase.
module pio_phase_seq #(
    parameter int unsigned STATES = 6,
    parameter int unsigned PHASES = 2,
    localparam int unsigned TOTAL = STATES * PHASES,
    localparam int unsigned CNT_W = $clog2(TOTAL)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] phase_idx,
    output logic             first_phase
);
    // Advance the phase index and wrap at the end of the machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_idx <= '0;
        else if (phase_idx == CNT_W'(TOTAL - 1))
            phase_idx <= '0;
        else
            phase_idx <= phase_idx + 1'b1;
    end

    // Phase 1 is the first phase of every state.
    always_comb first_phase = ((32'(phase_idx) % PHASES) == 0);
endmodule

// File: rtl/pio_sync.sv
// Two-stage synchronizer for the raw pad levels.
// Assumes pad levels are asynchronous to clk; adds two edges of delay.
module pio_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage1;

    // Shift the pad levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '1;
            q_sync <= '1;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/pio_pin_drv.sv
// Per-port driver stage: samples the latch in Phase 1, holds it in Phase 2,
// and decodes pull-down / strong pull-up / weak pull-up enables.
// OPEN_DRAIN=1 builds the port that also carries the external bus.
module pio_pin_drv #(
    parameter int unsigned W          = 8,
    parameter bit          OPEN_DRAIN = 1'b0,
    parameter bit          RST_ONES   = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         first_phase,
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] alt_val,
    input  logic         bus_en,
    input  logic [W-1:0] bus_val,
    output logic [W-1:0] smp_val,
    output logic [W-1:0] pd,
    output logic [W-1:0] spu,
    output logic [W-1:0] wpu
);
    localparam logic [W-1:0] RST_VAL = RST_ONES ? '1 : '0;

    logic [W-1:0] held_q;

    // Capture the latch at the end of each Phase 1 for use in Phase 2.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= RST_VAL;
        else if (first_phase)
            held_q <= latch_q;
    end

    // Transparent in Phase 1, holding in Phase 2.
    always_comb smp_val = first_phase ? latch_q : held_q;

    generate
        if (OPEN_DRAIN) begin : g_open_drain
            logic [W-1:0] unused_alt;
            assign unused_alt = alt_val;

            // Bus access drives both ways; otherwise only the pull-down is used.
            always_comb begin
                if (bus_en) begin
                    pd  = ~bus_val;
                    spu = bus_val;
                end else begin
                    pd  = ~smp_val;
                    spu = '0;
                end
                wpu = '0;
            end
        end else begin : g_quasi
            logic [W-1:0] eff;
            logic [W-1:0] prev_q;
            logic [W-1:0] boost_q;
            logic         unused_bus;
            assign unused_bus = bus_en ^ (^bus_val);

            // A latch 1 yields to the alternate output function.
            always_comb eff = smp_val & alt_val;

            // Remember the last driven value and extend a rise for one more phase.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prev_q  <= '1;
                    boost_q <= '0;
                end else begin
                    prev_q  <= eff;
                    boost_q <= eff & ~prev_q;
                end
            end

            // Decode the three driver enables from the driven value.
            always_comb begin
                pd  = ~eff;
                wpu = eff;
                spu = eff & (~prev_q | boost_q);
            end
        end
    endgenerate
endmodule

// File: rtl/pio_port_bank.sv
// Bank of port latches with phase-sampled pad drivers and synchronized reads.
// Port 0 is open drain and carries the external address/data bus; the other
// ports are quasi-bidirectional. All flat buses place port p at bits p*W.
module pio_port_bank #(
    parameter int unsigned NP = 6,
    parameter int unsigned W  = 8,
    localparam int unsigned PW    = $clog2(NP),
    localparam int unsigned FW    = NP * W,
    localparam int unsigned CNT_W = $clog2(pio_pkg::STATES_PER_CYCLE * pio_pkg::PHASES_PER_STATE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_port,
    input  logic [W-1:0]  wr_data,
    input  logic [PW-1:0] rd_port,
    input  logic          rd_latch,
    output logic [W-1:0]  rd_data,
    input  logic [FW-1:0] alt_out,
    output logic [FW-1:0] alt_in,
    input  logic          ext_bus_en,
    input  logic [W-1:0]  ext_ad_out,
    input  logic [FW-1:0] pad_in,
    output logic [FW-1:0] pd_en,
    output logic [FW-1:0] spu_en,
    output logic [FW-1:0] wpu_en
);
    logic [CNT_W-1:0] phase_idx;
    logic             first_phase;
    logic [FW-1:0]    latch_flat;
    logic [FW-1:0]    drv_flat;
    logic [FW-1:0]    pin_sync;

    pio_phase_seq #(
        .STATES(pio_pkg::STATES_PER_CYCLE),
        .PHASES(pio_pkg::PHASES_PER_STATE)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_idx  (phase_idx),
        .first_phase(first_phase)
    );

    pio_sync #(.WIDTH(FW)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(pad_in),
        .q_sync (pin_sync)
    );

    always_comb alt_in = pin_sync;

    generate
        for (genvar p = 0; p < NP; p++) begin : g_port
            localparam bit IS_BUS  = (p == 0);
            localparam bit HI_RST  = pio_pkg::resets_high(p);

            // Port latch: reset value, bus fill on port 0, then core writes.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    latch_flat[p*W +: W] <= HI_RST ? '1 : '0;
                else if (IS_BUS && ext_bus_en)
                    latch_flat[p*W +: W] <= '1;
                else if (wr_en && (wr_port == PW'(p)))
                    latch_flat[p*W +: W] <= wr_data;
            end

            pio_pin_drv #(
                .W         (W),
                .OPEN_DRAIN(IS_BUS),
                .RST_ONES  (HI_RST)
            ) u_drv (
                .clk        (clk),
                .rst_n      (rst_n),
                .first_phase(first_phase),
                .latch_q    (latch_flat[p*W +: W]),
                .alt_val    (alt_out[p*W +: W]),
                .bus_en     (ext_bus_en),
                .bus_val    (ext_ad_out),
                .smp_val    (drv_flat[p*W +: W]),
                .pd         (pd_en[p*W +: W]),
                .spu        (spu_en[p*W +: W]),
                .wpu        (wpu_en[p*W +: W])
            );
        end
    endgenerate

    // Read mux: latch for read-modify-write, synchronized pins otherwise.
    always_comb begin
        rd_data = '0;
        for (int p = 0; p < NP; p++) begin
            if (rd_port == PW'(p))
                rd_data = rd_latch ? latch_flat[p*W +: W] : pin_sync[p*W +: W];
        end
    end
endmodule

// File: rtl/pio_port_bank_chk.sv
// Property checker for the port bank, attached by bind below.
module pio_port_bank_chk #(
    parameter int unsigned NP    = 6,
    parameter int unsigned W     = 8,
    parameter int unsigned CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] phase_idx,
    input logic             first_phase,
    input logic [NP*W-1:0]  latch_flat,
    input logic [NP*W-1:0]  drv_flat,
    input logic             ext_bus_en,
    input logic [NP*W-1:0]  pd_en,
    input logic [NP*W-1:0]  spu_en,
    input logic [NP*W-1:0]  wpu_en
);
    localparam int unsigned FW = NP * W;
    localparam logic [FW-1:0] QMASK = {{(FW-W){1'b1}}, {W{1'b0}}};

    assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_idx == CNT_W'(11)) |=> (phase_idx == '0));

    assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phase_idx < CNT_W'(12));

    assert_drv_hold_p2_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !first_phase |-> $stable(drv_flat));

    assert_no_contention_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_en & (spu_en | wpu_en)) == '0);

    assert_spu_max_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (spu_en & $past(spu_en) & $past(spu_en, 2) & QMASK) == '0);

    assert_spu_with_weak_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (spu_en & ~wpu_en & QMASK) == '0);

    assert_p0_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_bus_en |-> (spu_en[W-1:0] == '0 && wpu_en[W-1:0] == '0));

    assert_bus_fills_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ext_bus_en |=> (latch_flat[W-1:0] == '1));
endmodule

bind pio_port_bank pio_port_bank_chk #(.NP(NP), .W(W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_idx  (phase_idx),
    .first_phase(first_phase),
    .latch_flat (latch_flat),
    .drv_flat   (drv_flat),
    .ext_bus_en (ext_bus_en),
    .pd_en      (pd_en),
    .spu_en     (spu_en),
    .wpu_en     (wpu_en)
);

// File: tb/test_pio_port_bank.sv
module test_pio_port_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 6;
    localparam int W  = 8;
    localparam int FW = NP * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_port = '0;
    logic [W-1:0]  wr_data = '0;
    logic [2:0]    rd_port = '0;
    logic          rd_latch = 1'b0;
    logic [W-1:0]  rd_data;
    logic [FW-1:0] alt_out = '1;
    logic [FW-1:0] alt_in;
    logic          ext_bus_en = 1'b0;
    logic [W-1:0]  ext_ad_out = '0;
    logic [FW-1:0] pad_in = '1;
    logic [FW-1:0] pd_en, spu_en, wpu_en;

    int errors = 0;
    int checks = 0;
    int ph = 0;
    bit done = 1'b0;

    pio_port_bank i_pio_port_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port),
        .wr_data(wr_data), .rd_port(rd_port), .rd_latch(rd_latch),
        .rd_data(rd_data), .alt_out(alt_out), .alt_in(alt_in),
        .ext_bus_en(ext_bus_en), .ext_ad_out(ext_ad_out), .pad_in(pad_in),
        .pd_en(pd_en), .spu_en(spu_en), .wpu_en(wpu_en)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Bench's own phase count, per R1/R2.
    always @(posedge clk) ph <= (!rst_n || ph == 11) ? 0 : ph + 1;

    // Vector: {port[2:0], data[7:0], alt[7:0], exp_pd[7:0], exp_wpu[7:0]}
    localparam logic [34:0] VEC [7] = '{
        {3'd1, 8'h00, 8'hFF, 8'hFF, 8'h00},
        {3'd1, 8'hA5, 8'hFF, 8'h5A, 8'hA5},
        {3'd2, 8'hFF, 8'h0F, 8'hF0, 8'h0F},
        {3'd0, 8'h3C, 8'hFF, 8'hC3, 8'h00},
        {3'd5, 8'hF0, 8'h33, 8'hCF, 8'h30},
        {3'd4, 8'h81, 8'hFF, 8'h7E, 8'h81},
        {3'd3, 8'h00, 8'hFF, 8'hFF, 8'h00}
    };

    task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_ph(input int target);
        while (ph != target) @(negedge clk);
    endtask

    function automatic logic [W-1:0] pick(input logic [FW-1:0] v, input int p);
        return v[p*W +: W];
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values through read-modify-write reads (R9 read path).
        rd_latch = 1'b1;
        for (int p = 0; p < NP; p++) begin
            rd_port = 3'(p);
            #1;
            chk(rd_data, (p == 0 || p == 3) ? 8'hFF : 8'h00, "R1 reset latch");
        end
        chk(pick(pd_en, 1), 8'hFF, "R1/R3 port1 pulls low in reset");
        chk(pick(pd_en, 0) | pick(wpu_en, 0) | pick(spu_en, 0), 8'h00, "R6 port0 floats in reset");
        chk(pick(wpu_en, 3), 8'hFF, "R1/R4 port3 weak high in reset");
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: write at the last phase, check at the first (R2, R3, R4, R6).
        for (int i = 0; i < 7; i++) begin
            wait_ph(11);
            alt_out[int'(VEC[i][34:32])*W +: W] = VEC[i][23:16];
            wr_en = 1'b1; wr_port = VEC[i][34:32]; wr_data = VEC[i][31:24];
            @(negedge clk);
            wr_en = 1'b0;
            chk(pick(pd_en, int'(VEC[i][34:32])), VEC[i][15:8], "R2/R3/R4/R6 pd at S1P1");
            chk(pick(wpu_en, int'(VEC[i][34:32])), VEC[i][7:0], "R4/R6 wpu at S1P1");
        end

        // R2: write in a Phase 1 cycle lands two cycles later.
        wait_ph(4);
        wr_en = 1'b1; wr_port = 3'd2; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        chk(pick(pd_en, 2), 8'hF0, "R2 old value held in Phase 2");
        @(negedge clk);
        chk(pick(pd_en, 2), 8'hFF, "R2 new value at next Phase 1");

        // R5: rising edge burst of strong pull-up lasts one state.
        wait_ph(11);
        alt_out[2*W +: W] = 8'hFF;
        wr_en = 1'b1; wr_port = 3'd2; wr_data = 8'hFF;
        @(negedge clk);
        wr_en = 1'b0;
        chk(pick(spu_en, 2), 8'hFF, "R5 strong pull-up first phase");
        chk(pick(pd_en, 2), 8'h00, "R3 pull-down off on rise");
        @(negedge clk);
        chk(pick(spu_en, 2), 8'hFF, "R5 strong pull-up second phase");
        @(negedge clk);
        chk(pick(spu_en, 2), 8'h00, "R5 strong pull-up ends");
        chk(pick(wpu_en, 2), 8'hFF, "R5 weak pull-up remains");

        // R7: bus access collides with a core write to port 0.
        wait_ph(3);
        ext_bus_en = 1'b1; ext_ad_out = 8'h5A;
        wr_en = 1'b1; wr_port = 3'd0; wr_data = 8'h00;
        #1;
        chk(pick(spu_en, 0), 8'h5A, "R7 bus drives high bits");
        chk(pick(pd_en, 0), 8'hA5, "R7 bus drives low bits");
        @(negedge clk);
        ext_bus_en = 1'b0; wr_en = 1'b0;
        rd_latch = 1'b1; rd_port = 3'd0;
        @(negedge clk);
        chk(rd_data, 8'hFF, "R7 latch filled with ones over core write");
        chk(pick(pd_en, 0) | pick(spu_en, 0) | pick(wpu_en, 0), 8'h00, "R6 port0 floats after bus");

        // R8: pin read and alternate input lag the pad by two edges.
        rd_latch = 1'b0; rd_port = 3'd1;
        pad_in[1*W +: W] = 8'h5A;
        @(negedge clk);
        chk(rd_data, 8'hFF, "R8 one edge after pad change");
        @(negedge clk);
        chk(rd_data, 8'h5A, "R8 pin read two edges after");
        chk(pick(alt_in, 1), 8'h5A, "R8 alternate input");

        // R9: read-modify-write returns latch while the pad is held low.
        rd_latch = 1'b1;
        #1;
        chk(rd_data, 8'hA5, "R9 latch read ignores pad");
        rd_port = 3'd7;
        #1;
        chk(rd_data, 8'h00, "R9 out-of-range port reads zero");

        // R9/R10: a write to port 7 changes no latch.
        wait_ph(1);
        wr_en = 1'b1; wr_port = 3'd7; wr_data = 8'h55;
        @(negedge clk);
        wr_en = 1'b0;
        rd_port = 3'd4;
        #1;
        chk(rd_data, 8'h81, "R9/R10 out-of-range write ignored");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule